// File: doc/BRIEF.md
# Cascadable Synchronous Preset Counter

This block is a synchronous binary up-counter made from a chain of identical 4-bit stages. Every state bit is registered on the rising clock edge, so all outputs move together. One edge can do any of four things, in this priority order: clear the count, load a parallel word, count up by one, or hold.

Counting is gated by two enables. The first, P, goes to every stage unchanged. The second, T, enters the lowest stage and is passed up the chain through each stage's ripple carry. A stage's carry is high only while its own T is high and its nibble is all ones. The next stage therefore advances exactly when every stage below it is at its maximum, and no external gating is needed. The carry of the top stage comes out of the block, so wider chains can be built from several blocks. Load overrides both enables. Clear overrides load and serves as the block's synchronous active-low reset.

Top module: `cascade_counter`

## Requirements
- R1: With clr_n low at a rising edge, count becomes 0 after that edge, whatever load_n, en_p, en_t and data_in are.
- R2: With clr_n high and load_n low at a rising edge, count becomes data_in after that edge, whatever en_p and en_t are.
- R3: With clr_n and load_n high and both en_p and en_t high, count increases by one after the edge, modulo 2^(4*STAGES).
- R4: With clr_n and load_n high and either en_p or en_t low, count keeps its value across the edge.
- R5: ripple_out is high exactly when en_t is high and every bit of count is 1. It follows en_t combinationally, within the same cycle.
- R6: While counting continuously, the count wraps from all ones to 0 and ripple_out is high for exactly that one cycle at the maximum.
- R7: The sequence clear, load 12, six counting edges, then en_p low gives a lowest nibble of 0, 12, 13, 14, 15, 0, 1, 2. The count then holds.
- R8: At the full count, ripple_out depends on en_t only. It stays high with en_p low and en_t high, and it is low with en_t low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clr_n | input | 1 | Synchronous clear and reset, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_p | input | 1 | Count enable applied to every stage |
| en_t | input | 1 | Count enable for the lowest stage; also qualifies ripple_out |
| data_in | input | 4*STAGES | Parallel load value |
| count | output | 4*STAGES | Current count |
| ripple_out | output | 1 | High while en_t is high and count is all ones |

## Verification
The hardest case to reach is a carry that crosses every stage at once: the whole word must sit at all ones while both enables are high. Random counting alone seldom gets there in a short run. The stimulus therefore loads values a few steps below the full count and below each nibble boundary, then counts through them. It also holds the full count with en_p low while toggling en_t, which separates the two enables' roles on the carry.

// File: rtl/cnt_pkg.sv
// Package: shared definitions for the cascadable counter.
// Assumes: nothing beyond IEEE 1800-2017.
package cnt_pkg;
    localparam int NIBBLE_W = 4;

    // Operation selected for one clock edge, in priority order.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
// Module: cnt_ctrl
// Picks the operation for the next edge from the control pins.
// Priority: clear, then load, then count, then hold.
// Assumes: all inputs are synchronous to the stage clock.
module cnt_ctrl
    import cnt_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);
    // Priority decode of the control pins.
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_p && en_t) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end
endmodule

// File: rtl/cnt_carry.sv
// Module: cnt_carry
// Terminal-count decode of one stage: high when the enable is high
// and the stage value is all ones. It is a NOR of the inverted bits,
// taken from registered state only.
// Assumes: q comes straight from flip-flops.
module cnt_carry #(
    parameter int W = 4
) (
    input  logic [W-1:0] q,
    input  logic         en_t,
    output logic         carry
);
    // All-ones detect gated by the trickle enable.
    always_comb begin
        carry = en_t & ~(|(~q));
    end
endmodule

// File: rtl/cnt_stage.sv
// Module: cnt_stage
// One W-bit counter stage: a register, its priority control and its
// carry decode. Stages are chained by feeding one stage's carry into
// the en_t of the next.
// Assumes: clr_n is synchronous and also serves as reset.
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_n,
    input  logic         en_p,
    input  logic         en_t,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         carry
);
    cnt_op_e op;
    logic    clr_seen;

    cnt_ctrl u_ctrl (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    cnt_carry #(.W(W)) u_carry (
        .q     (q),
        .en_t  (en_t),
        .carry (carry)
    );

    // State register: applies the selected operation on the rising edge.
    always_ff @(posedge clk) begin
        unique case (op)
            OP_CLEAR: q <= '0;
            OP_LOAD:  q <= din;
            OP_COUNT: q <= q + W'(1);
            default:  q <= q;
        endcase
    end

    // Remembers that a clear was applied on the previous edge.
    always_ff @(posedge clk) begin
        clr_seen <= !clr_n;
    end

    // R1: a clear on the previous edge leaves the stage at zero.
    always_ff @(posedge clk) begin
        if (clr_seen) begin
            p_clear_zero_r1: assert (q == '0)
                else $error("stage not zero after clear");
        end
    end

    // R2: load takes the data whatever the enables are.
    p_load_data_r2: assert property (@(posedge clk) disable iff (!clr_n)
        !load_n |=> q == $past(din));

    // R3: both enables high increments the stage by one.
    p_count_step_r3: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t) |=> q == W'($past(q) + W'(1)));

    // R4: either enable low holds the stage.
    p_hold_value_r4: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/cascade_counter.sv
// Module: cascade_counter
// STAGES counter stages of 4 bits each, chained through their ripple
// carries into one synchronous counter of 4*STAGES bits. en_p reaches
// every stage; en_t enters stage 0 and each stage's carry drives the
// next stage's en_t.
// Assumes: clr_n is held low for at least one edge after power-up.
module cascade_counter
    import cnt_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic                         clk,
    input  logic                         clr_n,
    input  logic                         load_n,
    input  logic                         en_p,
    input  logic                         en_t,
    input  logic [NIBBLE_W*STAGES-1:0]   data_in,
    output logic [NIBBLE_W*STAGES-1:0]   count,
    output logic                         ripple_out
);
    localparam int TOTAL_W = NIBBLE_W * STAGES;

    logic [STAGES:0] t_chain;

    // Head of the trickle chain is the external enable.
    always_comb begin
        t_chain[0] = en_t;
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        cnt_stage #(.W(NIBBLE_W)) u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .load_n (load_n),
            .en_p   (en_p),
            .en_t   (t_chain[s]),
            .din    (data_in[s*NIBBLE_W +: NIBBLE_W]),
            .q      (count[s*NIBBLE_W +: NIBBLE_W]),
            .carry  (t_chain[s+1])
        );
    end

    // Ripple carry of the whole word is the top stage's carry.
    always_comb begin
        ripple_out = t_chain[STAGES];
    end

    // R5: carry out only with en_t high and the full word at maximum.
    p_carry_full_r5: assert property (@(posedge clk) disable iff (!clr_n)
        ripple_out |-> (en_t && (count == {TOTAL_W{1'b1}})));

    // R6: counting from the maximum wraps the whole word to zero.
    p_wrap_zero_r6: assert property (@(posedge clk) disable iff (!clr_n)
        (load_n && en_p && en_t && count == {TOTAL_W{1'b1}}) |=> count == '0);

    // R8: en_p low does not remove the carry at the maximum.
    p_carry_p_free_r8: assert property (@(posedge clk) disable iff (!clr_n)
        (!en_p && en_t && count == {TOTAL_W{1'b1}}) |-> ripple_out);
endmodule

// File: tb/test_cascade_counter.sv
// Bench: constrained random plus directed stimulus against a model.
module test_cascade_counter;
    localparam int STAGES = 3;
    localparam int TW = 4 * STAGES;
    localparam logic [TW-1:0] MAXV = {TW{1'b1}};

    logic          clk = 1'b0;
    logic          clr_n = 1'b0;
    logic          load_n = 1'b1;
    logic          en_p = 1'b0;
    logic          en_t = 1'b0;
    logic [TW-1:0] data_in = '0;
    logic [TW-1:0] count;
    logic          ripple_out;

    int            n_checks = 0;
    int            n_fails = 0;
    bit            done = 1'b0;
    logic [TW-1:0] exp_q = '0;

    always #2 clk = ~clk;

    cascade_counter #(.STAGES(STAGES)) i_cascade_counter (
        .clk        (clk),
        .clr_n      (clr_n),
        .load_n     (load_n),
        .en_p       (en_p),
        .en_t       (en_t),
        .data_in    (data_in),
        .count      (count),
        .ripple_out (ripple_out)
    );

    function automatic logic [TW-1:0] model_next(logic c, logic l, logic p,
                                                 logic t, logic [TW-1:0] cur,
                                                 logic [TW-1:0] d);
        if (!c) return '0;
        if (!l) return d;
        if (p && t) return cur + TW'(1);
        return cur;
    endfunction

    function automatic logic model_carry(logic t, logic [TW-1:0] cur);
        return t && (cur == MAXV);
    endfunction

    task automatic check(string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One clock: drive after the falling edge, check carry, check count.
    task automatic step(logic c, logic l, logic p, logic t,
                        logic [TW-1:0] d, string tag);
        logic [TW-1:0] nxt;
        @(negedge clk);
        clr_n = c; load_n = l; en_p = p; en_t = t; data_in = d;
        #0.5;
        check({tag, " carry"}, TW'(ripple_out), TW'(model_carry(t, exp_q)));
        nxt = model_next(c, l, p, t, exp_q, d);
        @(posedge clk);
        #0.5;
        check({tag, " count"}, count, nxt);
        exp_q = nxt;
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1234);
        // R1: reset state, clear wins over load.
        step(0, 1, 1, 1, '0, "R1");
        step(0, 0, 1, 1, TW'(12'h5A5), "R1");
        // R7: clear, load 12, count six, inhibit.
        step(0, 1, 0, 0, '0, "R7");
        check("R7 nibble", TW'(count[3:0]), TW'(0));
        step(1, 0, 0, 0, TW'(12), "R7");
        check("R7 nibble", TW'(count[3:0]), TW'(12));
        for (int i = 0; i < 6; i++) begin
            step(1, 1, 1, 1, '0, "R7");
            check("R7 nibble", TW'(count[3:0]), TW'((13 + i) % 16));
        end
        step(1, 1, 0, 1, '0, "R7 hold");
        step(1, 1, 0, 1, '0, "R7 hold");
        check("R7 held", TW'(count[3:0]), TW'(2));
        // R2: load overrides both enables.
        step(1, 0, 1, 1, TW'(12'h3C7), "R2");
        // R4: either enable low holds.
        step(1, 1, 1, 0, '0, "R4");
        step(1, 1, 0, 1, '0, "R4");
        // R8: at maximum, carry follows en_t only.
        step(1, 0, 0, 0, MAXV, "R8");
        step(1, 1, 0, 1, '0, "R8");
        step(1, 1, 1, 0, '0, "R8");
        step(1, 1, 0, 0, '0, "R8");
        // R6: count through the full-word wrap.
        step(1, 0, 0, 0, MAXV - TW'(2), "R6");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, '0, "R6");
        // R3: cross each nibble boundary.
        step(1, 0, 0, 0, TW'(12'h0FE), "R3");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 1, '0, "R3");
        step(1, 0, 0, 0, TW'(12'hEFD), "R3");
        for (int i = 0; i < 5; i++) step(1, 1, 1, 1, '0, "R3");
        // R5: constrained random mix.
        for (int i = 0; i < 600; i++) begin
            logic c, l, p, t;
            logic [TW-1:0] d;
            c = ($urandom % 100) >= 2;
            l = ($urandom % 100) >= 8;
            p = ($urandom % 100) < 85;
            t = ($urandom % 100) < 85;
            d = (($urandom % 4) == 0) ? MAXV - TW'($urandom % 4)
                                      : TW'($urandom);
            step(c, l, p, t, d, "R5 random");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks, n_fails);
            $finish;
        end
    end
endmodule